// File: doc/BRIEF.md
# Multi-channel shadowed PWM generator

This block is a bank of pulse-width modulated outputs with a small register space of 32-bit words. Each channel is programmed with three counts, all in clock cycles: a period, a high time (duty) and a start delay (offset). Software writes these counts into a staging copy of each channel's settings. The running waveforms do not change until software issues a single global load command. The load moves every staged set into the running set in the same cycle and restarts all channel counters together, so that the channels share one phase reference.

A core reset bit holds every output low until software clears it. A channel with a running period of zero is switched off and its output stays low. Fixed identification words, a channel-count word and a free scratch word let software find and probe the block. Writes use a single-cycle strobe. Reads are combinational from the read address.

Top module: `shadow_pwm_gen`

## Requirements
- R1: Reads return fixed words at these word offsets: 0x00 gives 0x00020000 (major version 2 in bits 31:16), 0x04 gives the CORE_ID parameter (default 0x00000001), 0x0C gives 0x601A3471, and 0x14 gives the channel count NCH (default 4).
- R2: The scratch word at 0x08 reads back the last value written to it.
- R3: Config word 0x10, bit 0, is a core reset, and it is 1 after reset. While it is 1, every output is low, even if channels have been loaded. Once it is cleared, enabled channels start from the beginning of their offset, then their period. Reading 0x10 returns the core reset bit in bit 0 and zero in every other bit, including bit 1.
- R4: For channel ch, the period is at 0x40+4*ch, the duty at 0x80+4*ch and the offset at 0xC0+4*ch. A write to one of these changes only the staged value. The output keeps its running waveform, and reads return the staged value.
- R5: Writing 0x10 with bit 1 set is a load. In that edge it copies the staged period, duty and offset of every channel into the running set and restarts every channel, even one whose settings did not change.
- R6: With running period P>0, duty D and offset 0, the output in cycle k after the load edge (k=0 is the first cycle) is high exactly when (k mod P) < D.
- R7: A duty greater than or equal to the period gives an output that stays high once the offset has passed.
- R8: A channel whose running period is 0 has its output held low.
- R9: With offset O, the output is low for the first O cycles after the load edge. From then on it follows R6 with k replaced by k-O.
- R10: Writes to 0x00, 0x04, 0x0C and 0x14 are ignored. Reads of unmapped addresses return 0. These include 0x18 to 0x3C, channel slots at or above NCH, and 0xFC.
- R11: After reset, the staged and running period, duty and offset of every channel and the scratch word are 0, and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 8 | Byte address of the write (bits 1:0 ignored) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read (bits 1:0 ignored) |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
A corrupt staged value appears on the read port at once. A corrupt running value only appears on pwm_out, and only from the first cycle after the next load. The bench therefore compares every output, cycle by cycle, against a period/duty/offset model for several dozen cycles after each load. A counter that wraps one count late or early drifts by one cycle per period, so a few periods are enough to expose it. A load that fails to restart one channel shows up as a phase shift against the model within the first period.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
    localparam logic [31:0] MAGIC_WORD   = 32'h601A_3471;
    localparam logic [31:0] VERSION_WORD = 32'h0002_0000;
    // word indices (byte address bits 7:2)
    localparam logic [5:0] IDX_VERSION = 6'd0;
    localparam logic [5:0] IDX_ID      = 6'd1;
    localparam logic [5:0] IDX_SCRATCH = 6'd2;
    localparam logic [5:0] IDX_MAGIC   = 6'd3;
    localparam logic [5:0] IDX_CFG     = 6'd4;
    localparam logic [5:0] IDX_COUNT   = 6'd5;
    // channel banks selected by index bits 5:4
    localparam logic [1:0] BANK_PER  = 2'd1;
    localparam logic [1:0] BANK_DUTY = 2'd2;
    localparam logic [1:0] BANK_OFF  = 2'd3;
    localparam int CFG_RST_BIT  = 0;
    localparam int CFG_LOAD_BIT = 1;
endpackage

// File: rtl/pwmg_regs.sv
module pwmg_regs
    import pwmg_pkg::*;
#(
    parameter int          NCH     = 4,
    parameter int          W       = 32,
    parameter logic [31:0] CORE_ID = 32'h0000_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [31:0]             wr_data,
    input  logic [7:0]              rd_addr,
    output logic [31:0]             rd_data,
    output logic                    core_on,
    output logic                    load_pulse,
    output logic [NCH-1:0][W-1:0]   ac_per,
    output logic [NCH-1:0][W-1:0]   ac_duty,
    output logic [NCH-1:0][W-1:0]   ac_off,
    output logic [NCH-1:0][W-1:0]   sh_off
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                  core_rst;
        logic [31:0]           scratch;
        logic [NCH-1:0][W-1:0] sh_per;
        logic [NCH-1:0][W-1:0] sh_duty;
        logic [NCH-1:0][W-1:0] sh_off;
        logic [NCH-1:0][W-1:0] ac_per;
        logic [NCH-1:0][W-1:0] ac_duty;
        logic [NCH-1:0][W-1:0] ac_off;
    } regs_t;

    regs_t st_d, st_q;

    logic [5:0]     wr_idx, rd_idx;
    logic [CHW-1:0] wr_ch, rd_ch;
    logic           wr_ch_ok, rd_ch_ok;
    logic           load_d;
    logic           unused_lsb;

    assign wr_idx     = wr_addr[7:2];
    assign rd_idx     = rd_addr[7:2];
    assign wr_ch      = wr_idx[CHW-1:0];
    assign rd_ch      = rd_idx[CHW-1:0];
    assign wr_ch_ok   = ({28'd0, wr_idx[3:0]} < 32'(NCH));
    assign rd_ch_ok   = ({28'd0, rd_idx[3:0]} < 32'(NCH));
    assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};

    always_comb begin
        st_d   = st_q;
        load_d = 1'b0;
        if (wr_en) begin
            case (wr_idx)
                IDX_SCRATCH: st_d.scratch = wr_data;
                IDX_CFG: begin
                    st_d.core_rst = wr_data[CFG_RST_BIT];
                    load_d        = wr_data[CFG_LOAD_BIT];
                end
                default: begin
                    if (wr_idx[5:4] != 2'd0 && wr_ch_ok) begin
                        case (wr_idx[5:4])
                            BANK_PER:  st_d.sh_per[wr_ch]  = wr_data[W-1:0];
                            BANK_DUTY: st_d.sh_duty[wr_ch] = wr_data[W-1:0];
                            default:   st_d.sh_off[wr_ch]  = wr_data[W-1:0];
                        endcase
                    end
                end
            endcase
        end
        if (load_d) begin
            st_d.ac_per  = st_q.sh_per;
            st_d.ac_duty = st_q.sh_duty;
            st_d.ac_off  = st_q.sh_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.core_rst <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = 32'd0;
        case (rd_idx)
            IDX_VERSION: rd_data = VERSION_WORD;
            IDX_ID:      rd_data = CORE_ID;
            IDX_SCRATCH: rd_data = st_q.scratch;
            IDX_MAGIC:   rd_data = MAGIC_WORD;
            IDX_CFG:     rd_data = {31'd0, st_q.core_rst};
            IDX_COUNT:   rd_data = 32'(NCH);
            default: begin
                if (rd_idx[5:4] != 2'd0 && rd_ch_ok) begin
                    case (rd_idx[5:4])
                        BANK_PER:  rd_data = 32'(st_q.sh_per[rd_ch]);
                        BANK_DUTY: rd_data = 32'(st_q.sh_duty[rd_ch]);
                        default:   rd_data = 32'(st_q.sh_off[rd_ch]);
                    endcase
                end
            end
        endcase
    end

    assign core_on    = ~st_q.core_rst;
    assign load_pulse = load_d;
    assign ac_per     = st_q.ac_per;
    assign ac_duty    = st_q.ac_duty;
    assign ac_off     = st_q.ac_off;
    assign sh_off     = st_q.sh_off;
endmodule

// File: rtl/pwmg_chan.sv
module pwmg_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         load,
    input  logic [W-1:0] per,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] off,
    input  logic [W-1:0] off_next,
    output logic         pwm
);
    typedef struct packed {
        logic         waiting;
        logic [W-1:0] cnt;
    } chan_t;

    chan_t c_d, c_q;
    logic  run;

    assign run = enable && (per != '0);

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.waiting = (off_next != '0);
            c_d.cnt     = '0;
        end else if (!run) begin
            c_d.waiting = (off != '0);
            c_d.cnt     = '0;
        end else if (c_q.waiting) begin
            if (c_q.cnt == off - W'(1)) begin
                c_d.waiting = 1'b0;
                c_d.cnt     = '0;
            end else begin
                c_d.cnt = c_q.cnt + W'(1);
            end
        end else begin
            c_d.cnt = (c_q.cnt == per - W'(1)) ? '0 : c_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pwm = run && !c_q.waiting && (c_q.cnt < duty);
endmodule

// File: rtl/shadow_pwm_gen.sv
module shadow_pwm_gen #(
    parameter int          NCH     = 4,
    parameter int          W       = 32,
    parameter logic [31:0] CORE_ID = 32'h0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [31:0]     wr_data,
    input  logic [7:0]      rd_addr,
    output logic [31:0]     rd_data,
    output logic [NCH-1:0]  pwm_out
);
    logic                  core_on;
    logic                  load_pulse;
    logic [NCH-1:0][W-1:0] ac_per, ac_duty, ac_off, sh_off;

    pwmg_regs #(.NCH(NCH), .W(W), .CORE_ID(CORE_ID)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .core_on    (core_on),
        .load_pulse (load_pulse),
        .ac_per     (ac_per),
        .ac_duty    (ac_duty),
        .ac_off     (ac_off),
        .sh_off     (sh_off)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwmg_chan #(.W(W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (core_on),
            .load     (load_pulse),
            .per      (ac_per[i]),
            .duty     (ac_duty[i]),
            .off      (ac_off[i]),
            .off_next (sh_off[i]),
            .pwm      (pwm_out[i])
        );
    end
endmodule

// File: rtl/pwmg_chk.sv
module pwmg_chk
    import pwmg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [7:0]            wr_addr,
    input logic [31:0]           wr_data,
    input logic [7:0]            rd_addr,
    input logic [31:0]           rd_data,
    input logic [NCH-1:0]        pwm_out,
    input logic                  core_on,
    input logic [NCH-1:0][W-1:0] ac_per
);
    // R1
    magic_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[7:2] == IDX_MAGIC) |-> (rd_data == MAGIC_WORD));

    // R2
    scratch_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr[7:2] == IDX_SCRATCH) && $past(wr_en && (wr_addr[7:2] == IDX_SCRATCH)))
        |-> (rd_data == $past(wr_data)));

    // R3
    core_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on |-> (pwm_out == '0));

    // R3
    cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[7:2] == IDX_CFG) |-> (rd_data[31:1] == 31'd0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr[7:2] > IDX_COUNT) && (rd_addr[7:2] < 6'd16)) |-> (rd_data == 32'd0));

    for (genvar i = 0; i < NCH; i++) begin : g_off
        // R8
        zero_period_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ac_per[i] == '0) |-> !pwm_out[i]);
    end
endmodule

bind shadow_pwm_gen pwmg_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pwm_out (pwm_out),
    .core_on (core_on),
    .ac_per  (ac_per)
);

// File: tb/shadow_pwm_gen_bench.sv
module shadow_pwm_gen_bench;
    localparam int NCH = 4;
    localparam int NV  = 6;
    // stimulus table: period, duty, offset per vector (R6 R7 R8 R9)
    localparam int VP [NV] = '{5, 4, 3, 6, 0, 8};
    localparam int VD [NV] = '{2, 4, 7, 1, 3, 5};
    localparam int VO [NV] = '{0, 0, 2, 3, 0, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [31:0]    wr_data = '0;
    logic [7:0]     rd_addr = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pwm_out;

    int cyc = 0;
    int load_cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shadow_pwm_gen u_shadow_pwm_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    function automatic bit model(int k, int p, int d, int o);
        if (p == 0 || k < o) return 1'b0;
        return ((k - o) % p) < d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_load(logic hold);
        wr(8'h10, {30'd0, 1'b1, hold});
        load_cyc = cyc;
    endtask

    task automatic watch(string req, int ch, int p, int d, int o, int ncyc);
        int  bad = 0;
        int  fk = 0;
        logic fa = 1'b0;
        logic fe = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== model(cyc - load_cyc, p, d, o)) begin
                if (bad == 0) begin
                    fk = cyc - load_cyc; fa = pwm_out[ch]; fe = model(fk, p, d, o);
                end
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: ch%0d cycle %0d actual %b expected %b (%0d mismatches)",
                     req, ch, fk, fa, fe, bad);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11 outputs", 32'(pwm_out), 32'd0);
        rd_chk("R11 config", 8'h10, 32'd1);
        rd_chk("R11 period", 8'h40, 32'd0);
        rd_chk("R11 duty", 8'h84, 32'd0);
        rd_chk("R11 offset", 8'hCC, 32'd0);
        rd_chk("R11 scratch", 8'h08, 32'd0);

        // R1 identification
        rd_chk("R1 version", 8'h00, 32'h0002_0000);
        rd_chk("R1 id", 8'h04, 32'h0000_0001);
        rd_chk("R1 magic", 8'h0C, 32'h601A_3471);
        rd_chk("R1 count", 8'h14, 32'd4);

        // R2 scratch
        wr(8'h08, 32'hA5A5_1234);
        rd_chk("R2 scratch", 8'h08, 32'hA5A5_1234);
        wr(8'h08, 32'h0F0F_F0F0);
        rd_chk("R2 scratch rewrite", 8'h08, 32'h0F0F_F0F0);

        // R10 read-only and unmapped
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R10 magic write ignored", 8'h0C, 32'h601A_3471);
        wr(8'h14, 32'd0);
        rd_chk("R10 count write ignored", 8'h14, 32'd4);
        wr(8'h00, 32'h1234_5678);
        rd_chk("R10 version write ignored", 8'h00, 32'h0002_0000);
        rd_chk("R10 unmapped 0x20", 8'h20, 32'd0);
        rd_chk("R10 absent channel 0x50", 8'h50, 32'd0);
        rd_chk("R10 absent channel 0xFC", 8'hFC, 32'd0);

        // R3 core reset holds outputs low even after a load
        wr(8'h40, 32'd4);
        wr(8'h80, 32'd2);
        do_load(1'b1);
        watch("R3 held", 0, 0, 0, 0, 12);
        rd_chk("R3 config readback", 8'h10, 32'd1);
        wr(8'h10, 32'd0);
        load_cyc = cyc;
        watch("R3 release", 0, 4, 2, 0, 12);
        rd_chk("R3 config cleared", 8'h10, 32'd0);

        // R4 staged writes leave the running waveform alone
        wr(8'h40, 32'd10);
        wr(8'h80, 32'd10);
        watch("R4 running unchanged", 0, 4, 2, 0, 16);
        rd_chk("R4 staged period", 8'h40, 32'd10);
        rd_chk("R4 staged duty", 8'h80, 32'd10);

        // table walk: R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < NCH; c++) begin
                wr(8'(8'h40 + 4 * c), 32'(VP[(v + c) % NV]));
                wr(8'(8'h80 + 4 * c), 32'(VD[(v + c) % NV]));
                wr(8'(8'hC0 + 4 * c), 32'(VO[(v + c) % NV]));
            end
            do_load(1'b0);
            for (int c = 0; c < NCH; c++)
                watch("R5 R6 R7 R8 R9 vector", c,
                      VP[(v + c) % NV], VD[(v + c) % NV], VO[(v + c) % NV], 24);
        end

        // R5 realign: load again with nothing changed, all channels restart
        do_load(1'b0);
        for (int c = 0; c < NCH; c++)
            watch("R5 realign", c, VP[(NV - 1 + c) % NV], VD[(NV - 1 + c) % NV],
                  VO[(NV - 1 + c) % NV], 20);

        // R8 switch channel 0 off with a zero period
        wr(8'h40, 32'd0);
        do_load(1'b0);
        watch("R8 zero period", 0, 0, 0, 0, 16);

        summary();
        $finish;
    end
endmodule